// File: doc/BRIEF.md
# Sink AUX Request/Reply Mailbox

This block sits between the request decoder of a display sink's auxiliary channel and an embedded processor. A decoded request (command nibble, 20-bit address, byte count and up to fifteen payload bytes) arrives as one strobe. The block latches the request into readable byte registers, marks a message as pending and, if enabled, raises an interrupt. Software reads the request, fills reply bytes through the same byte window, and writes the reply command and reply byte count. That write hands the reply to the transmitter with a valid/ready handshake.

A single window of eighteen byte registers serves both directions. On read, window entry 0 returns address bits [15:8], entry 1 returns address bits [7:0], entry 2 returns the request length, and entry n (n from 3 to 17) returns request payload byte n-3. On write, window entry n (n from 0 to 16) stores reply byte n. Reading the command register also acknowledges the interrupt.

Top module: `aux_sink_mailbox`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `rep_valid_o` is low.
- R2: A request strobe while no message is pending latches it. Offset 1 then reads {command[3:0], address[19:16]} in bits 7:0. Offsets 2, 3 and 4 read address[15:8], address[7:0] and the length. Bit 31 of offset 0 (message pending) reads 1.
- R3: Offsets 5 to 19 read request payload bytes 0 to 14 in bits 7:0, with bits 31:8 zero. Payload byte k is `req_data_i[8k+7:8k]`.
- R4: `irq_o` rises one cycle after a request is latched while the enable bit (offset 0, bit 0) is 1. It is never high while that bit is 0 or no message is pending.
- R5: `irq_o` falls one cycle after software reads offset 1, or after it writes 0 to the enable bit.
- R6: Bit 30 of offset 0 reads 1 only while a message is pending and no reply is being sent. It reads 0 while the block waits for a request or sends a reply.
- R7: A write to offset 2+n (n from 0 to 16) stores reply byte n, which appears as `rep_data_o[8n+7:8n]`. A write to offset 19 changes nothing. A write to offset 1 while a message is pending and no reply is in flight takes the reply command from bits 3:0 and the reply count from bits 12:8. One cycle later `rep_valid_o` is high and the pending flag is clear.
- R8: While `rep_valid_o` is high and `rep_ready_i` is low, `rep_cmd_o`, `rep_len_o` and `rep_data_o` hold and reply-byte writes are ignored. One cycle after a cycle where both are high, `rep_valid_o` is low.
- R9: A request that arrives while a message is pending is dropped, and the latched request is unchanged. It sets the sticky overflow bit (offset 0, bit 1). Writing 1 to that bit clears it.
- R10: A reply-command write while no message is pending has no effect. `rep_valid_o` stays low.
- R11: Reads of offsets 20 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle strobe: a decoded request is present |
| req_cmd_i | input | 4 | Request command nibble (read/write indication and type) |
| req_addr_i | input | 20 | Request address |
| req_len_i | input | 8 | Request length, 1 to 255 |
| req_data_i | input | 120 | Request payload bytes 0 to 14, byte k at bits 8k+7:8k |
| reg_addr_i | input | 5 | Register word offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (acknowledges the interrupt at offset 1) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt to the processor |
| rep_valid_o | output | 1 | Reply ready for the transmitter |
| rep_ready_i | input | 1 | Transmitter accepts the reply |
| rep_cmd_o | output | 4 | Reply command |
| rep_len_o | output | 5 | Number of reply bytes |
| rep_data_o | output | 136 | Reply bytes 0 to 16, byte n at bits 8n+7:8n |

## Verification
Every state change (request latch, register write, command-read acknowledge, reply launch, handshake completion) lands on the clock edge that samples its strobe. Its result is therefore visible one cycle later. Read data is combinational from that state, so a read issued in the cycle after a stimulus already sees the new value. The bench drives strobes just after a rising edge. It compares the read data and port values at the following falling edge, one register stage after the edge that consumed the strobe. Read expectations are queued by the driver and retired by a monitor in the cycle the read strobe is present.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_CMD  = 1;
  localparam int unsigned OFF_WIN  = 2;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_OVF  = 1;
  localparam int unsigned BIT_RDY  = 30;
  localparam int unsigned BIT_MSG  = 31;
  localparam int unsigned CMD_W    = 4;
  localparam int unsigned ADR_W    = 20;
endpackage

// File: rtl/mbx_req_capture.sv
module mbx_req_capture #(
  parameter int unsigned REQ_BYTES = 15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic [mbx_pkg::CMD_W-1:0]     req_cmd_i,
  input  logic [mbx_pkg::ADR_W-1:0]     req_addr_i,
  input  logic [7:0]                    req_len_i,
  input  logic [REQ_BYTES*8-1:0]        req_data_i,
  input  logic                          clr_msg_i,
  input  logic                          clr_ovf_i,
  output logic                          accept_o,
  output logic                          msg_ready_o,
  output logic                          ovf_o,
  output logic [mbx_pkg::CMD_W-1:0]     cmd_o,
  output logic [mbx_pkg::ADR_W-1:0]     addr_o,
  output logic [7:0]                    len_o,
  output logic [REQ_BYTES*8-1:0]        data_o
);
  logic msg_q, ovf_q;

  assign accept_o    = req_valid_i && !msg_q;
  assign msg_ready_o = msg_q;
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q  <= 1'b0;
      cmd_o  <= '0;
      addr_o <= '0;
      len_o  <= '0;
      data_o <= '0;
    end else if (accept_o) begin
      msg_q  <= 1'b1;
      cmd_o  <= req_cmd_i;
      addr_o <= req_addr_i;
      len_o  <= req_len_i;
      data_o <= req_data_i;
    end else if (clr_msg_i) begin
      msg_q <= 1'b0;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (req_valid_i && msg_q) ovf_q <= 1'b1;
    else if (clr_ovf_i)            ovf_q <= 1'b0;
  end

  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !msg_q) |=> (msg_q && addr_o == $past(req_addr_i)));

  p_no_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && msg_q) |=> (ovf_q && $stable(addr_o) && $stable(data_o) && $stable(len_o)));
endmodule

// File: rtl/mbx_reply_ctrl.sv
module mbx_reply_ctrl #(
  parameter int unsigned REP_BYTES = 17,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned LEN_W     = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          byte_we_i,
  input  logic [IDX_W-1:0]              byte_idx_i,
  input  logic [7:0]                    byte_i,
  input  logic                          launch_i,
  input  logic [mbx_pkg::CMD_W-1:0]     cmd_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic                          rep_ready_i,
  output logic                          busy_o,
  output logic [mbx_pkg::CMD_W-1:0]     rep_cmd_o,
  output logic [LEN_W-1:0]              rep_len_o,
  output logic [REP_BYTES*8-1:0]        rep_data_o
);
  logic busy_q;
  assign busy_o = busy_q;

  for (genvar g = 0; g < REP_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rep_data_o[g*8 +: 8] <= '0;
      else if (byte_we_i && !busy_q && byte_idx_i == IDX_W'(g))
        rep_data_o[g*8 +: 8] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rep_cmd_o <= '0;
      rep_len_o <= '0;
    end else if (launch_i && !busy_q) begin
      busy_q    <= 1'b1;
      rep_cmd_o <= cmd_i;
      rep_len_o <= len_i;
    end else if (busy_q && rep_ready_i) begin
      busy_q <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rep_ready_i) |=>
      (busy_q && $stable(rep_data_o) && $stable(rep_cmd_o) && $stable(rep_len_o)));

  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rep_ready_i) |=> !busy_q);
endmodule

// File: rtl/mbx_reg_read.sv
module mbx_reg_read #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned WIN_REGS  = 18,
  parameter int unsigned REQ_BYTES = 15
) (
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic                          irq_en_i,
  input  logic                          ovf_i,
  input  logic                          msg_ready_i,
  input  logic                          rep_busy_i,
  input  logic [mbx_pkg::CMD_W-1:0]     cmd_i,
  input  logic [mbx_pkg::ADR_W-1:0]     addr_i,
  input  logic [7:0]                    len_i,
  input  logic [REQ_BYTES*8-1:0]        data_i,
  output logic [31:0]                   rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(mbx_pkg::OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(mbx_pkg::OFF_CMD);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(mbx_pkg::OFF_WIN);

  logic [7:0] win_rd [WIN_REGS];

  for (genvar n = 0; n < WIN_REGS; n++) begin : g_win
    if (n == 0) begin : g_ahi
      assign win_rd[n] = addr_i[15:8];
    end else if (n == 1) begin : g_alo
      assign win_rd[n] = addr_i[7:0];
    end else if (n == 2) begin : g_len
      assign win_rd[n] = len_i;
    end else begin : g_dat
      assign win_rd[n] = data_i[(n-3)*8 +: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == A_CTRL) begin
      rdata_o[mbx_pkg::BIT_MSG] = msg_ready_i;
      rdata_o[mbx_pkg::BIT_RDY] = msg_ready_i && !rep_busy_i;
      rdata_o[mbx_pkg::BIT_OVF] = ovf_i;
      rdata_o[mbx_pkg::BIT_EN]  = irq_en_i;
    end else if (reg_addr_i == A_CMD) begin
      rdata_o[7:0] = {cmd_i, addr_i[19:16]};
    end
    for (int k = 0; k < WIN_REGS; k++) begin
      if (reg_addr_i == A_WIN + ADDR_W'(k)) rdata_o[7:0] = win_rd[k];
    end
  end
endmodule

// File: rtl/aux_sink_mailbox.sv
module aux_sink_mailbox #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned WIN_REGS = 18,
  localparam int unsigned REQ_BYTES = WIN_REGS - 3,
  localparam int unsigned REP_BYTES = WIN_REGS - 1,
  localparam int unsigned LEN_W     = $clog2(REP_BYTES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [3:0]                req_cmd_i,
  input  logic [19:0]               req_addr_i,
  input  logic [7:0]                req_len_i,
  input  logic [REQ_BYTES*8-1:0]    req_data_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      irq_o,
  output logic                      rep_valid_o,
  input  logic                      rep_ready_i,
  output logic [3:0]                rep_cmd_o,
  output logic [LEN_W-1:0]          rep_len_o,
  output logic [REP_BYTES*8-1:0]    rep_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(mbx_pkg::OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(mbx_pkg::OFF_CMD);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(mbx_pkg::OFF_WIN);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(mbx_pkg::OFF_WIN + WIN_REGS);

  logic wr_ctrl, wr_cmd, rd_cmd, win_hit, launch, accept;
  logic msg_ready, ovf, irq_en_q, irq_ack_q;
  logic [ADDR_W-1:0] win_idx;
  logic [3:0] cap_cmd;
  logic [19:0] cap_addr;
  logic [7:0] cap_len;
  logic [REQ_BYTES*8-1:0] cap_data;

  assign wr_ctrl = reg_wr_i && reg_addr_i == A_CTRL;
  assign wr_cmd  = reg_wr_i && reg_addr_i == A_CMD;
  assign rd_cmd  = reg_rd_i && reg_addr_i == A_CMD;
  assign win_hit = reg_addr_i >= A_WIN && reg_addr_i < A_END;
  assign win_idx = reg_addr_i - A_WIN;
  assign launch  = wr_cmd && msg_ready && !rep_valid_o;

  mbx_req_capture #(.REQ_BYTES(REQ_BYTES)) u_cap (
    .clk_i, .rst_ni, .req_valid_i, .req_cmd_i, .req_addr_i, .req_len_i, .req_data_i,
    .clr_msg_i(launch),
    .clr_ovf_i(wr_ctrl && reg_wdata_i[mbx_pkg::BIT_OVF]),
    .accept_o(accept), .msg_ready_o(msg_ready), .ovf_o(ovf),
    .cmd_o(cap_cmd), .addr_o(cap_addr), .len_o(cap_len), .data_o(cap_data)
  );

  mbx_reply_ctrl #(.REP_BYTES(REP_BYTES), .IDX_W(ADDR_W), .LEN_W(LEN_W)) u_rep (
    .clk_i, .rst_ni,
    .byte_we_i(reg_wr_i && win_hit), .byte_idx_i(win_idx), .byte_i(reg_wdata_i[7:0]),
    .launch_i(launch), .cmd_i(reg_wdata_i[3:0]), .len_i(reg_wdata_i[8 +: LEN_W]),
    .rep_ready_i, .busy_o(rep_valid_o), .rep_cmd_o, .rep_len_o, .rep_data_o
  );

  mbx_reg_read #(.ADDR_W(ADDR_W), .WIN_REGS(WIN_REGS), .REQ_BYTES(REQ_BYTES)) u_rd (
    .reg_addr_i, .irq_en_i(irq_en_q), .ovf_i(ovf), .msg_ready_i(msg_ready),
    .rep_busy_i(rep_valid_o), .cmd_i(cap_cmd), .addr_i(cap_addr), .len_i(cap_len),
    .data_i(cap_data), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_en_q <= 1'b0;
    else if (wr_ctrl) irq_en_q <= reg_wdata_i[mbx_pkg::BIT_EN];
  end

  // a fresh request re-arms the interrupt; a command read acknowledges it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_ack_q <= 1'b0;
    else if (accept) irq_ack_q <= 1'b0;
    else if (rd_cmd) irq_ack_q <= 1'b1;
  end

  assign irq_o = irq_en_q && msg_ready && !irq_ack_q;

  p_irq_raise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && irq_en_q && !wr_ctrl) |=> irq_o);

  p_irq_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && !accept) |=> !irq_o);

  p_irq_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !reg_wdata_i[mbx_pkg::BIT_EN]) |=> !irq_o);

  p_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CTRL && reg_rdata_o[mbx_pkg::BIT_RDY]) |-> !rep_valid_o);

  p_launch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (rep_valid_o && !reg_rdata_o[mbx_pkg::BIT_RDY]));

  p_no_launch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !msg_ready && !rep_valid_o) |=> !rep_valid_o);

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= A_END) |-> reg_rdata_o == '0);
endmodule

// File: tb/tb_aux_sink_mailbox.sv
module tb_aux_sink_mailbox;
  localparam int REQ_BYTES = 15;
  localparam int REP_BYTES = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [3:0] req_cmd_i = '0;
  logic [19:0] req_addr_i = '0;
  logic [7:0] req_len_i = '0;
  logic [REQ_BYTES*8-1:0] req_data_i = '0;
  logic [4:0] reg_addr_i = '0;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic irq_o, rep_valid_o;
  logic rep_ready_i = 1'b0;
  logic [3:0] rep_cmd_o;
  logic [4:0] rep_len_o;
  logic [REP_BYTES*8-1:0] rep_data_o;
  logic [REP_BYTES*8-1:0] exp_rep;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  aux_sink_mailbox dut (.*, .clk_i(clk));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic [135:0] act, input logic [135:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [3:0] c, input logic [19:0] a, input logic [7:0] l,
                          input logic [7:0] base);
    req_cmd_i = c; req_addr_i = a; req_len_i = l;
    for (int k = 0; k < REQ_BYTES; k++) req_data_i[k*8 +: 8] = base + 8'(k);
    req_valid_i = 1'b1;
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0;
  endtask

  // driver: queue the expectation, present the read for one cycle
  task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
    reg_addr_i = a; reg_rd_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    tick();
    reg_rd_i = 1'b0;
  endtask

  // monitor: retire one expectation per read strobe
  always @(negedge clk) begin
    if (reg_rd_i && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata_o !== e) begin
        errors++;
        $display("FAIL %s: actual %08h expected %08h", t, reg_rdata_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    check(irq_o, 0, "R1 irq");
    check(rep_valid_o, 0, "R1 rep_valid");
    rd_check(5'd0, 32'h0, "R1 ctrl");
    rd_check(5'd1, 32'h0, "R1 cmd");
    rd_check(5'd2, 32'h0, "R1 byte0");

    reg_write(5'd0, 32'h1);
    check(irq_o, 0, "R4 no msg");
    send_req(4'h9, 20'h5A1B2, 8'h10, 8'hA0);
    check(irq_o, 1, "R4 irq raised");
    rd_check(5'd0, 32'hC000_0001, "R2 R6 ctrl pending");
    rd_check(5'd2, 32'hA1, "R2 addr hi");
    rd_check(5'd3, 32'hB2, "R2 addr lo");
    rd_check(5'd4, 32'h10, "R2 len");
    rd_check(5'd5, 32'hA0, "R3 data0");
    rd_check(5'd19, 32'hAE, "R3 data14");
    check(irq_o, 1, "R5 byte reads keep irq");
    rd_check(5'd1, 32'h95, "R2 cmd");
    check(irq_o, 0, "R5 cmd read acks");

    send_req(4'h1, 20'h12345, 8'h01, 8'h00);
    rd_check(5'd2, 32'hA1, "R9 dropped");
    rd_check(5'd5, 32'hA0, "R9 data kept");
    rd_check(5'd0, 32'hC000_0003, "R9 overflow");

    reg_write(5'd2, 32'h11);
    reg_write(5'd3, 32'h22);
    reg_write(5'd18, 32'h33);
    reg_write(5'd19, 32'h44);
    exp_rep = '0;
    exp_rep[7:0] = 8'h11; exp_rep[15:8] = 8'h22; exp_rep[16*8 +: 8] = 8'h33;
    check(rep_data_o, exp_rep, "R7 reply bytes");
    rd_check(5'd19, 32'hAE, "R7 offset 19 write ignored");
    check(rep_valid_o, 0, "R7 not yet sent");

    reg_write(5'd1, 32'h0000_0302);
    check(rep_valid_o, 1, "R7 launched");
    check(rep_cmd_o, 4'h2, "R7 cmd");
    check(rep_len_o, 5'd3, "R7 len");
    rd_check(5'd0, 32'h0000_0003, "R6 R7 sending");
    reg_write(5'd2, 32'h99);
    tick();
    check(rep_valid_o, 1, "R8 held");
    check(rep_data_o, exp_rep, "R8 data stable");
    rep_ready_i = 1'b1;
    tick();
    rep_ready_i = 1'b0;
    check(rep_valid_o, 0, "R8 handshake done");

    reg_write(5'd1, 32'h0000_0100);
    check(rep_valid_o, 0, "R10 no pending msg");
    reg_write(5'd0, 32'h3);
    rd_check(5'd0, 32'h1, "R9 overflow cleared");

    send_req(4'h4, 20'h00001, 8'h02, 8'h50);
    check(irq_o, 1, "R4 second irq");
    reg_write(5'd0, 32'h0);
    check(irq_o, 0, "R5 enable cleared");
    rd_check(5'd0, 32'hC000_0000, "R6 ready to reply");
    rd_check(5'd5, 32'h50, "R3 new data");

    rd_check(5'd20, 32'h0, "R11 off20");
    rd_check(5'd25, 32'h0, "R11 off25");
    rd_check(5'd31, 32'h0, "R11 off31");

    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule